// File: doc/BRIEF.md
# Directional Tap and Double-Tap Detector

This block watches a stream of signed three-axis acceleration samples and decides whether the sensor was struck once or twice in quick succession. Each sample is compared with the one before it. The largest per-axis change is the performance index. When this index lies strictly between a low threshold and a doubled high threshold, the sample counts as a tap candidate. The axis and sign of that change give one of six directions.

The first accepted tap arms a sample-count timer. A later candidate counts as the second tap of a double tap only if it arrives after both the latency count and the separation count and before the window count. If no such candidate arrives, a single tap is reported when the window runs out. Results are latched into a six-bit direction vector and two event flags, which hold until a release strobe. A per-direction enable mask suppresses unwanted directions. A fast-rate input makes each timer count span several samples. A one-cycle clear input drops any event in progress.

Top module: `tap_detector`

## Requirements
- R1: After reset, `tap_dir`, `tap_single` and `tap_double` are all zero.
- R2: On a valid sample the index is the largest absolute per-axis difference from the previous valid sample, where the first previous sample after reset is zero. The sample is a candidate only when the index is greater than `thr_lo` and less than twice `thr_hi`.
- R3: The direction is taken from the axis with the largest difference; on a tie X wins over Y and Y wins over Z. The direction bit is 2*axis+positive, with axis X=0, Y=1, Z=2, so bit0 is X negative, bit1 X positive, bit2 Y negative, bit3 Y positive, bit4 Z negative and bit5 Z positive. A latched event always reports a non-zero direction.
- R4: A candidate whose direction bit is 0 in `dir_mask` is ignored. It neither starts nor ends a tap sequence.
- R5: While armed, a candidate whose elapsed count is below `tm_latency` or below `tm_sep` is ignored.
- R6: While armed, a candidate whose elapsed count is at least max(`tm_latency`, `tm_sep`) and less than `tm_window` sets `tap_double`. It reports the first tap's direction and ends the sequence.
- R7: While armed, the first sample whose elapsed count reaches `tm_window` without qualifying as a double sets `tap_single` with the first tap's direction. Any candidate on that same sample is discarded.
- R8: The elapsed count is measured in valid samples since the first tap, one count per sample when `fast_rate` is 0 and one count per FAST_DIV (4) samples when `fast_rate` is 1.
- R9: The flags and direction bits stay set and OR together across events until `rel_strobe` clears them. When a release and an event occur in the same cycle, the new event survives and the older bits are cleared.
- R10: `clr` returns the sequence to idle and zeroes the timers. Latched flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | One-cycle abort of the tap sequence |
| smp_valid | input | 1 | Sample strobe |
| smp_x | input | DW | Signed X sample |
| smp_y | input | DW | Signed Y sample |
| smp_z | input | DW | Signed Z sample |
| thr_lo | input | THW | Low index threshold |
| thr_hi | input | THW | High index threshold, doubled before use |
| tm_latency | input | TW | Latency count |
| tm_window | input | TW | Window count |
| tm_sep | input | TW | Minimum separation count |
| fast_rate | input | 1 | Timer count spans FAST_DIV samples |
| dir_mask | input | 6 | Per-direction enable, 1 enables |
| rel_strobe | input | 1 | Clears latched results |
| tap_dir | output | 6 | Latched direction bits |
| tap_single | output | 1 | Latched single-tap flag |
| tap_double | output | 1 | Latched double-tap flag |

## Verification
Every result is decided on the clock edge that captures the deciding sample. The flags and direction bits are visible right after that edge, with no extra pipeline stage. A release or clear takes effect on the edge that captures it. The bench therefore drives each input on a falling edge and compares the outputs on the next falling edge, so each comparison lands one edge after the stimulus. Window and gap sweeps predict the edge on which a single or double tap appears from the sample count alone.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int NAXIS = 3;
    localparam int NDIR  = 2 * NAXIS;

    typedef logic [NDIR-1:0] dir_vec_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic     is_sgl;
        logic     is_dbl;
        dir_vec_t dir;
    } tap_evt_t;

    // direction bit index = 2*axis + positive
    function automatic dir_vec_t dir_onehot(input logic [1:0] axis, input logic positive);
        dir_vec_t v;
        v = dir_vec_t'(1) << {axis, positive};
        return v;
    endfunction

endpackage

// File: rtl/tap_index.sv
module tap_index
    import tap_pkg::*;
#(
    parameter int DW  = 12,
    parameter int THW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_x,
    input  logic signed [DW-1:0] smp_y,
    input  logic signed [DW-1:0] smp_z,
    input  logic [THW-1:0]       thr_lo,
    input  logic [THW-1:0]       thr_hi,
    input  dir_vec_t             dir_mask,
    output dir_vec_t             raw_dir,
    output logic                 hit_ok
);
    localparam int MW = DW + 1;
    localparam int CW = (MW > THW + 1) ? MW : THW + 1;

    logic signed [DW-1:0] cur [NAXIS];
    logic signed [DW-1:0] prv [NAXIS];
    logic signed [DW:0]   dif [NAXIS];
    logic [DW:0]          mag [NAXIS];

    logic [1:0]  best_ax;
    logic [DW:0] best_mag;
    logic        best_pos;
    logic        in_band;

    assign cur[0] = smp_x;
    assign cur[1] = smp_y;
    assign cur[2] = smp_z;

    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
        assign dif[a] = {cur[a][DW-1], cur[a]} - {prv[a][DW-1], prv[a]};
        assign mag[a] = dif[a][DW] ? (~dif[a] + 1'b1) : dif[a];

        always_ff @(posedge clk) begin
            if (rst) begin
                prv[a] <= '0;
            end else if (smp_valid) begin
                prv[a] <= cur[a];
            end
        end
    end

    // strict compare keeps the lower axis on ties
    always_comb begin
        best_ax  = 2'd0;
        best_mag = mag[0];
        for (int a = 1; a < NAXIS; a++) begin
            if (mag[a] > best_mag) begin
                best_ax  = 2'(a);
                best_mag = mag[a];
            end
        end
    end

    assign best_pos = ~dif[best_ax][DW];
    assign raw_dir  = dir_onehot(best_ax, best_pos);
    assign in_band  = (CW'(best_mag) > CW'(thr_lo)) &&
                      (CW'(best_mag) < CW'({thr_hi, 1'b0}));
    assign hit_ok   = smp_valid && in_band && (|(raw_dir & dir_mask));

endmodule

// File: rtl/tap_timer.sv
module tap_timer #(
    parameter int TW       = 8,
    parameter int FAST_DIV = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          adv,
    input  logic          fast,
    output logic [TW-1:0] elapsed,
    output logic [TW-1:0] elapsed_nx
);
    localparam int PW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(FAST_DIV - 1);
    localparam logic [TW-1:0] CNT_MAX  = {TW{1'b1}};

    logic [PW-1:0] pre;
    logic [PW-1:0] pre_nx;
    logic          wrap;
    logic          tick;

    assign wrap       = ~fast || (pre == PRE_LAST);
    assign tick       = adv && wrap;
    assign elapsed_nx = (tick && (elapsed != CNT_MAX)) ? elapsed + 1'b1 : elapsed;
    assign pre_nx     = wrap ? '0 : pre + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            elapsed <= '0;
            pre     <= '0;
        end else if (adv) begin
            elapsed <= elapsed_nx;
            pre     <= pre_nx;
        end
    end

endmodule

// File: rtl/tap_sequencer.sv
module tap_sequencer
    import tap_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          smp_valid,
    input  logic          hit_ok,
    input  dir_vec_t      raw_dir,
    input  logic [TW-1:0] elapsed_nx,
    input  logic [TW-1:0] tm_latency,
    input  logic [TW-1:0] tm_window,
    input  logic [TW-1:0] tm_sep,
    output logic          restart,
    output logic          adv,
    output logic          armed,
    output tap_evt_t      evt
);
    seq_state_e    st;
    dir_vec_t      first_dir;
    logic          start;
    logic [TW-1:0] min_gap;

    assign armed   = (st == SEQ_ARMED);
    assign start   = ~clr && (st == SEQ_IDLE) && hit_ok;
    assign adv     = ~clr && armed && smp_valid;
    assign restart = start || clr;
    assign min_gap = (tm_latency > tm_sep) ? tm_latency : tm_sep;

    always_comb begin
        evt.is_dbl = adv && hit_ok && (elapsed_nx >= min_gap) && (elapsed_nx < tm_window);
        evt.is_sgl = adv && ~evt.is_dbl && (elapsed_nx >= tm_window);
        evt.dir    = first_dir;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEQ_IDLE;
            first_dir <= '0;
        end else if (clr) begin
            st <= SEQ_IDLE;
        end else if (start) begin
            st        <= SEQ_ARMED;
            first_dir <= raw_dir;
        end else if (evt.is_sgl || evt.is_dbl) begin
            st <= SEQ_IDLE;
        end
    end

endmodule

// File: rtl/tap_detector.sv
module tap_detector
    import tap_pkg::*;
#(
    parameter int DW       = 12,
    parameter int THW      = 8,
    parameter int TW       = 8,
    parameter int FAST_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_x,
    input  logic signed [DW-1:0] smp_y,
    input  logic signed [DW-1:0] smp_z,
    input  logic [THW-1:0]       thr_lo,
    input  logic [THW-1:0]       thr_hi,
    input  logic [TW-1:0]        tm_latency,
    input  logic [TW-1:0]        tm_window,
    input  logic [TW-1:0]        tm_sep,
    input  logic                 fast_rate,
    input  logic [5:0]           dir_mask,
    input  logic                 rel_strobe,
    output logic [5:0]           tap_dir,
    output logic                 tap_single,
    output logic                 tap_double
);
    dir_vec_t      raw_dir;
    logic          hit_ok;
    logic          restart;
    logic          adv;
    logic          armed;
    logic [TW-1:0] elapsed;
    logic [TW-1:0] elapsed_nx;
    tap_evt_t      evt;

    tap_index #(
        .DW  (DW),
        .THW (THW)
    ) u_index (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_x     (smp_x),
        .smp_y     (smp_y),
        .smp_z     (smp_z),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .dir_mask  (dir_mask),
        .raw_dir   (raw_dir),
        .hit_ok    (hit_ok)
    );

    tap_timer #(
        .TW       (TW),
        .FAST_DIV (FAST_DIV)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .adv        (adv),
        .fast       (fast_rate),
        .elapsed    (elapsed),
        .elapsed_nx (elapsed_nx)
    );

    tap_sequencer #(
        .TW (TW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .smp_valid  (smp_valid),
        .hit_ok     (hit_ok),
        .raw_dir    (raw_dir),
        .elapsed_nx (elapsed_nx),
        .tm_latency (tm_latency),
        .tm_window  (tm_window),
        .tm_sep     (tm_sep),
        .restart    (restart),
        .adv        (adv),
        .armed      (armed),
        .evt        (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_single <= 1'b0;
            tap_double <= 1'b0;
            tap_dir    <= '0;
        end else begin
            tap_single <= (tap_single && ~rel_strobe) || evt.is_sgl;
            tap_double <= (tap_double && ~rel_strobe) || evt.is_dbl;
            tap_dir    <= (rel_strobe ? '0 : tap_dir) |
                          ((evt.is_sgl || evt.is_dbl) ? evt.dir : '0);
        end
    end

endmodule

// File: rtl/tap_detector_chk.sv
module tap_detector_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          clr,
    input logic          smp_valid,
    input logic          rel_strobe,
    input logic          fast_rate,
    input logic [5:0]    dir_mask,
    input logic [5:0]    raw_dir,
    input logic          armed,
    input logic          adv,
    input logic [TW-1:0] elapsed,
    input logic [5:0]    tap_dir,
    input logic          tap_single,
    input logic          tap_double
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    AST_DIR_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (tap_single || tap_double) == (tap_dir != 6'd0)); // R3

    AST_ARM_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past((raw_dir & dir_mask) != 6'd0)); // R4

    AST_DOUBLE_FROM_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(tap_double) |-> $past(armed)); // R6

    AST_SLOW_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && $past(adv) && !$past(fast_rate) && ($past(elapsed) != CNT_MAX))
        |-> (elapsed == TW'($past(elapsed) + 1'b1))); // R8

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(smp_valid) && !$past(rel_strobe))
        |-> ($stable(tap_single) && $stable(tap_double) && $stable(tap_dir))); // R9

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(rel_strobe) && !$past(smp_valid))
        |-> (!tap_single && !tap_double && (tap_dir == 6'd0))); // R9

    AST_CLEAR_IDLES: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !armed); // R10

endmodule

bind tap_detector tap_detector_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .smp_valid  (smp_valid),
    .rel_strobe (rel_strobe),
    .fast_rate  (fast_rate),
    .dir_mask   (dir_mask),
    .raw_dir    (raw_dir),
    .armed      (armed),
    .adv        (adv),
    .elapsed    (elapsed),
    .tap_dir    (tap_dir),
    .tap_single (tap_single),
    .tap_double (tap_double)
);

// File: tb/tap_detector_tb_top.sv
`timescale 1ns/1ps
module tap_detector_tb_top;
    localparam int DW   = 12;
    localparam int THW  = 8;
    localparam int TW   = 8;
    localparam int FDIV = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst = 1'b1;
    logic                 clr = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [DW-1:0] smp_x = '0;
    logic signed [DW-1:0] smp_y = '0;
    logic signed [DW-1:0] smp_z = '0;
    logic [THW-1:0]       thr_lo = 8'd20;
    logic [THW-1:0]       thr_hi = 8'd30;
    logic [TW-1:0]        tm_latency = 8'd2;
    logic [TW-1:0]        tm_window = 8'd4;
    logic [TW-1:0]        tm_sep = 8'd2;
    logic                 fast_rate = 1'b0;
    logic [5:0]           dir_mask = 6'h3F;
    logic                 rel_strobe = 1'b0;
    logic [5:0]           tap_dir;
    logic                 tap_single;
    logic                 tap_double;

    tap_detector #(.DW(DW), .THW(THW), .TW(TW), .FAST_DIV(FDIV)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .thr_lo(thr_lo), .thr_hi(thr_hi),
        .tm_latency(tm_latency), .tm_window(tm_window), .tm_sep(tm_sep),
        .fast_rate(fast_rate), .dir_mask(dir_mask), .rel_strobe(rel_strobe),
        .tap_dir(tap_dir), .tap_single(tap_single), .tap_double(tap_double)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expectation state derived from the requirements
    int         m_prev [3];
    bit         m_armed;
    int         m_e;
    int         m_pre;
    logic [5:0] m_first;
    logic [5:0] e_dir;
    bit         e_sgl;
    bit         e_dbl;
    int         cx, cy, cz;

    task automatic check(input string req, input logic [5:0] xd, input bit xs, input bit xb);
        n_chk++;
        if (tap_dir !== xd || tap_single !== xs || tap_double !== xb) begin
            n_bad++;
            $display("FAIL %s: got dir=%b sgl=%b dbl=%b, expected dir=%b sgl=%b dbl=%b",
                     req, tap_dir, tap_single, tap_double, xd, xs, xb);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b, expected %b", req, act, exp);
        end
    endtask

    task automatic model(input bit v, input int x, input int y, input int z,
                         input bit rel, input bit cl);
        int d [3];
        int mg [3];
        int cur [3];
        int ba;
        int mx;
        bit hit;
        bit wrap;
        bit es;
        bit eb;
        logic [5:0] dr;
        hit = 1'b0;
        es  = 1'b0;
        eb  = 1'b0;
        dr  = '0;
        cur[0] = x; cur[1] = y; cur[2] = z;
        if (v) begin
            for (int a = 0; a < 3; a++) begin
                d[a]  = cur[a] - m_prev[a];
                mg[a] = (d[a] < 0) ? -d[a] : d[a];
            end
            ba = 0;
            for (int a = 1; a < 3; a++) if (mg[a] > mg[ba]) ba = a;
            dr  = 6'(1) << (2 * ba + ((d[ba] > 0) ? 1 : 0));
            hit = (mg[ba] > int'(thr_lo)) && (mg[ba] < 2 * int'(thr_hi)) && ((dr & dir_mask) != 0);
            for (int a = 0; a < 3; a++) m_prev[a] = cur[a];
        end
        if (cl) begin
            m_armed = 1'b0; m_e = 0; m_pre = 0;
        end else if (!m_armed && hit) begin
            m_armed = 1'b1; m_e = 0; m_pre = 0; m_first = dr;
        end else if (m_armed && v) begin
            wrap  = !fast_rate || (m_pre == FDIV - 1);
            m_pre = wrap ? 0 : m_pre + 1;
            if (wrap && m_e < 255) m_e++;
            mx = (tm_latency > tm_sep) ? int'(tm_latency) : int'(tm_sep);
            if (hit && m_e >= mx && m_e < int'(tm_window)) eb = 1'b1;
            else if (m_e >= int'(tm_window)) es = 1'b1;
            if (es || eb) m_armed = 1'b0;
        end
        if (rel) begin
            e_dir = '0; e_sgl = 1'b0; e_dbl = 1'b0;
        end
        if (es || eb) e_dir = e_dir | m_first;
        if (es) e_sgl = 1'b1;
        if (eb) e_dbl = 1'b1;
    endtask

    task automatic cyc(input bit v, input int x, input int y, input int z,
                       input bit rel, input bit cl, input string req);
        smp_valid  = v;
        smp_x      = DW'(x);
        smp_y      = DW'(y);
        smp_z      = DW'(z);
        rel_strobe = rel;
        clr        = cl;
        model(v, x, y, z, rel, cl);
        @(negedge clk);
        smp_valid  = 1'b0;
        rel_strobe = 1'b0;
        clr        = 1'b0;
        check(req, e_dir, e_sgl, e_dbl);
    endtask

    task automatic go(input int x, input int y, input int z, input string req);
        cx = x; cy = y; cz = z;
        cyc(1'b1, x, y, z, 1'b0, 1'b0, req);
    endtask

    task automatic hold(input string req);
        cyc(1'b1, cx, cy, cz, 1'b0, 1'b0, req);
    endtask

    task automatic settle(input string req);
        for (int i = 0; i < 200 && m_armed; i++) hold(req);
    endtask

    task automatic relse(input string req);
        cyc(1'b0, cx, cy, cz, 1'b1, 1'b0, req);
    endtask

    function automatic int toward0(input int v);
        if (v > 0) return v - 10;
        if (v < 0) return v + 10;
        return 0;
    endfunction

    task automatic ramp(input string req);
        while (cx != 0 || cy != 0 || cz != 0) go(toward0(cx), toward0(cy), toward0(cz), req);
    endtask

    task automatic cfg(input int lo, input int hi, input int lat, input int win,
                       input int sep, input bit fst, input logic [5:0] msk);
        thr_lo = THW'(lo); thr_hi = THW'(hi);
        tm_latency = TW'(lat); tm_window = TW'(win); tm_sep = TW'(sep);
        fast_rate = fst; dir_mask = msk;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): got no finish, expected finish within 200000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int e;
        int mx;
        bit xd;
        bit inb;
        string tag;
        for (int a = 0; a < 3; a++) m_prev[a] = 0;
        m_armed = 1'b0; m_e = 0; m_pre = 0; m_first = '0;
        e_dir = '0; e_sgl = 1'b0; e_dbl = 1'b0;
        cx = 0; cy = 0; cz = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 6'd0, 1'b0, 1'b0);

        // R2: index band with the doubled high threshold
        for (int hi = 12; hi <= 30; hi += 18) begin
            cfg(20, hi, 2, 4, 2, 1'b0, 6'h3F);
            for (int amp = 10; amp <= 70; amp++) begin
                go(0, 0, 0, "R2");
                go(amp, 0, 0, "R2");
                go(0, 0, 0, "R2");
                settle("R2");
                inb = (amp > 20) && (amp < 2 * hi);
                check("R2", inb ? 6'b000010 : 6'b000000, inb, 1'b0);
                relse("R2");
            end
        end

        // R3: axis and sign encoding, tie order
        cfg(20, 30, 2, 4, 2, 1'b0, 6'h3F);
        for (int ax = 0; ax < 3; ax++) begin
            for (int sg = 0; sg < 2; sg++) begin
                go(0, 0, 0, "R3");
                go(ax == 0 ? (sg ? 40 : -40) : 0,
                   ax == 1 ? (sg ? 40 : -40) : 0,
                   ax == 2 ? (sg ? 40 : -40) : 0, "R3");
                go(0, 0, 0, "R3");
                settle("R3");
                check("R3", 6'(1) << (2 * ax + sg), 1'b1, 1'b0);
                relse("R3");
            end
        end
        go(40, -40, 0, "R3"); go(0, 0, 0, "R3"); settle("R3");
        check("R3", 6'b000010, 1'b1, 1'b0); relse("R3");
        go(30, -45, 10, "R3"); go(0, 0, 0, "R3"); settle("R3");
        check("R3", 6'b000100, 1'b1, 1'b0); relse("R3");
        go(0, 40, 40, "R3"); go(0, 0, 0, "R3"); settle("R3");
        check("R3", 6'b001000, 1'b1, 1'b0); relse("R3");

        // R4: every mask against every direction
        for (int m = 0; m < 64; m++) begin
            for (int k = 0; k < 6; k++) begin
                cfg(20, 30, 2, 4, 2, 1'b0, 6'(m));
                go(0, 0, 0, "R4");
                go((k / 2) == 0 ? ((k % 2) ? 40 : -40) : 0,
                   (k / 2) == 1 ? ((k % 2) ? 40 : -40) : 0,
                   (k / 2) == 2 ? ((k % 2) ? 40 : -40) : 0, "R4");
                go(0, 0, 0, "R4");
                settle("R4");
                chk_bit("R4", tap_dir[k], 1'(m >> k));
                relse("R4");
            end
        end

        // R5, R6, R7, R8: second-tap gap sweep
        for (int fst = 0; fst < 2; fst++) begin
            for (int lat = 1; lat <= 3; lat += 2) begin
                for (int sep = 2; sep <= 4; sep += 2) begin
                    for (int gap = 1; gap <= (fst ? 28 : 9); gap++) begin
                        cfg(20, 30, lat, 6, sep, 1'(fst), 6'h3F);
                        e  = fst ? gap / FDIV : gap;
                        mx = (lat > sep) ? lat : sep;
                        xd = (e >= mx) && (e < 6);
                        tag = fst ? "R8" : ((e < mx) ? "R5" : ((e < 6) ? "R6" : "R7"));
                        go(40, 0, 0, tag);
                        for (int i = 1; i < gap; i++) hold(tag);
                        go(40, 0, 40, tag);
                        settle(tag);
                        chk_bit(tag, tap_double, xd);
                        chk_bit(tag, tap_single, !xd);
                        if (xd) chk_bit(tag, tap_dir[1], 1'b1);
                        ramp(tag);
                        relse(tag);
                    end
                end
            end
        end

        // R9: accumulation and release colliding with an event
        cfg(20, 30, 2, 4, 2, 1'b0, 6'h3F);
        go(40, 0, 0, "R9"); settle("R9"); ramp("R9");
        go(0, -40, 0, "R9"); settle("R9");
        check("R9", 6'b000110, 1'b1, 1'b0);
        ramp("R9");
        go(0, 0, 40, "R9");
        hold("R9"); hold("R9"); hold("R9");
        cyc(1'b1, 0, 0, 40, 1'b1, 1'b0, "R9");
        check("R9", 6'b100000, 1'b1, 1'b0);
        relse("R9");
        check("R9", 6'b000000, 1'b0, 1'b0);
        ramp("R9");

        // R10: clear aborts the sequence and keeps latched results
        go(0, 40, 0, "R10"); settle("R10"); ramp("R10");
        go(40, 0, 0, "R10");
        cyc(1'b0, 40, 0, 0, 1'b0, 1'b1, "R10");
        for (int i = 0; i < 10; i++) hold("R10");
        check("R10", 6'b001000, 1'b1, 1'b0);
        ramp("R10");
        go(0, 0, 40, "R10");
        hold("R10"); hold("R10"); hold("R10");
        check("R10", 6'b001000, 1'b1, 1'b0);
        hold("R10");
        check("R10", 6'b101000, 1'b1, 1'b0);
        relse("R10");
        ramp("R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule